// File: doc/BRIEF.md
# Dual Condition-Code Compare Unit

This block holds the two condition-code flags of a vector shader core and does the two jobs that touch them. When a compare is issued, it compares the x components of two operands and, separately, their y components. Each lane has its own compare mode, and each result goes into its own flag on the next clock edge. The flags persist until the next compare or the start of a new shader invocation, which clears them.

For a conditional branch on the condition codes, the block checks each flag against a reference bit supplied by the branch instruction. It then merges the two checks according to a 2-bit combine mode and drives a single branch-taken signal. This path is combinational on the flags that are already stored, so a branch issued in the cycle right after a compare sees that compare's result. Operand components arrive as signed integers that stand in for floating-point values.

Top module: `cond_code_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, both flags are 0 after that edge. `flags_o[0]` is the x flag and `flags_o[1]` is the y flag.
- R2: A high `start_i` at a clock edge clears both flags to 0. It takes priority over a compare issued in the same cycle.
- R3: With `cmp_valid_i` high and `start_i` low, each flag takes the result of its lane's comparison at the next clock edge. The x flag compares `x_a_i` with `x_b_i`, and the y flag compares `y_a_i` with `y_b_i`.
- R4: The x and y lanes use independent mode inputs (`x_mode_i`, `y_mode_i`). The mode codes are 0 = equal, 1 = not equal, 2 = a less than b, 3 = a less or equal b, 4 = a greater than b, 5 = a greater or equal b.
- R5: A lane whose mode code is 6 or 7 leaves its flag unchanged during a compare, while the other lane still updates.
- R6: When neither `cmp_valid_i` nor `start_i` is high, both flags keep their values.
- R7: The x check is true when the x flag equals `ref_x_i`. The y check is true when the y flag equals `ref_y_i`.
- R8: `branch_taken_o` is combinational from the stored flags. Depending on `combine_i`, it is the OR of the two checks (0), the AND of the two checks (1), the x check only (2), or the y check only (3).
- R9: Operands are compared as two's-complement values, so a negative operand is less than a non-negative one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | New shader invocation; clears both flags |
| cmp_valid_i | input | 1 | Compare instruction issued this cycle |
| x_a_i | input | DATA_W | First operand, x component (signed) |
| x_b_i | input | DATA_W | Second operand, x component (signed) |
| y_a_i | input | DATA_W | First operand, y component (signed) |
| y_b_i | input | DATA_W | Second operand, y component (signed) |
| x_mode_i | input | 3 | Compare mode for the x lane |
| y_mode_i | input | 3 | Compare mode for the y lane |
| ref_x_i | input | 1 | Reference bit for the x flag check |
| ref_y_i | input | 1 | Reference bit for the y flag check |
| combine_i | input | 2 | Combine mode for the two checks |
| flags_o | output | 2 | Stored flags: bit 0 = x, bit 1 = y |
| branch_taken_o | output | 1 | Branch condition result |

## Verification
Random stimulus draws operands from a narrow signed range centred on zero, so equal, smaller and larger pairs occur with similar frequency. Under every mode, this exposes a mode that confuses strict with non-strict ordering or swaps operands.

Directed cases cover the following:
- A negative-versus-positive pair, which separates a signed compare from an unsigned one.
- Differing x and y modes, which catches lanes sharing a mode.
- Undefined mode codes, which must leave only their own flag untouched.
- A start coinciding with a compare, which shows the clear priority.

Each combine mode is driven against several flag and reference pairings, which separates OR from AND and each single-lane mode from the other.

// File: rtl/cc_pkg.sv
// Shared types for the condition-code compare unit.
// Assumes two lanes (x, y); encodings below are part of the block's interface.
package cc_pkg;

    localparam int NUM_LANES = 2;

    typedef enum logic [2:0] {
        CMP_EQ = 3'd0,
        CMP_NE = 3'd1,
        CMP_LT = 3'd2,
        CMP_LE = 3'd3,
        CMP_GT = 3'd4,
        CMP_GE = 3'd5
    } cmp_mode_e;

    typedef enum logic [1:0] {
        CMB_OR  = 2'd0,
        CMB_AND = 2'd1,
        CMB_X   = 2'd2,
        CMB_Y   = 2'd3
    } combine_e;

endpackage

// File: rtl/cc_lane_compare.sv
// One lane comparator: evaluates a against b under a 3-bit mode.
// Assumes two's-complement operands. known_o is low for undefined
// mode codes, in which case hit_o carries no meaning.
module cc_lane_compare
    import cc_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic signed [DATA_W-1:0] a_i,
    input  logic signed [DATA_W-1:0] b_i,
    input  logic        [2:0]        mode_i,
    output logic                     hit_o,
    output logic                     known_o
);

    logic is_eq;
    logic is_lt;

    // Primitive relations shared by all modes
    always_comb begin
        is_eq = (a_i == b_i);
        is_lt = (a_i < b_i);
    end

    // Mode decode onto the primitive relations
    always_comb begin
        hit_o   = 1'b0;
        known_o = 1'b1;
        case (mode_i)
            CMP_EQ:  hit_o = is_eq;
            CMP_NE:  hit_o = !is_eq;
            CMP_LT:  hit_o = is_lt;
            CMP_LE:  hit_o = is_lt || is_eq;
            CMP_GT:  hit_o = !(is_lt || is_eq);
            CMP_GE:  hit_o = !is_lt;
            default: known_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/cc_flag_cell.sv
// A single condition-code flag register.
// Assumes synchronous active-low reset; clear has priority over load.
module cc_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic load_i,
    input  logic d_i,
    output logic q_o
);

    // Flag storage with reset, clear and conditional load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= 1'b0;
        end else if (clear_i) begin
            q_o <= 1'b0;
        end else if (load_i) begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/cc_branch_eval.sv
// Branch condition evaluator: matches each flag against its reference
// bit and merges the two matches under the combine mode.
// Purely combinational; assumes flags come from registers.
module cc_branch_eval
    import cc_pkg::*;
(
    input  logic [NUM_LANES-1:0] flags_i,
    input  logic [NUM_LANES-1:0] ref_i,
    input  logic [1:0]           combine_i,
    output logic                 taken_o
);

    logic [NUM_LANES-1:0] match;

    // Per-lane equality against the reference bit
    always_comb begin
        match = ~(flags_i ^ ref_i);
    end

    // Merge the two lane matches
    always_comb begin
        case (combine_i)
            CMB_OR:  taken_o = |match;
            CMB_AND: taken_o = &match;
            CMB_X:   taken_o = match[0];
            default: taken_o = match[1];
        endcase
    end

endmodule

// File: rtl/cond_code_unit.sv
// Dual condition-code compare unit (top).
// On a compare, lane 0 (x) and lane 1 (y) are compared under their own
// modes and stored in two flags on the next edge; undefined modes keep
// the lane's flag. start_i clears both flags with priority. The branch
// condition is formed combinationally from the stored flags.
module cond_code_unit
    import cc_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cmp_valid_i,
    input  logic [DATA_W-1:0] x_a_i,
    input  logic [DATA_W-1:0] x_b_i,
    input  logic [DATA_W-1:0] y_a_i,
    input  logic [DATA_W-1:0] y_b_i,
    input  logic [2:0]        x_mode_i,
    input  logic [2:0]        y_mode_i,
    input  logic              ref_x_i,
    input  logic              ref_y_i,
    input  logic [1:0]        combine_i,
    output logic [1:0]        flags_o,
    output logic              branch_taken_o
);

    logic signed [DATA_W-1:0] lane_a    [NUM_LANES];
    logic signed [DATA_W-1:0] lane_b    [NUM_LANES];
    logic        [2:0]        lane_mode [NUM_LANES];
    logic [NUM_LANES-1:0]     lane_hit;
    logic [NUM_LANES-1:0]     lane_known;
    logic [NUM_LANES-1:0]     flag_q;

    // Gather the x and y operand fields into lane arrays
    always_comb begin
        lane_a[0]    = x_a_i;
        lane_b[0]    = x_b_i;
        lane_mode[0] = x_mode_i;
        lane_a[1]    = y_a_i;
        lane_b[1]    = y_b_i;
        lane_mode[1] = y_mode_i;
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        cc_lane_compare #(.DATA_W(DATA_W)) u_cmp (
            .a_i     (lane_a[g]),
            .b_i     (lane_b[g]),
            .mode_i  (lane_mode[g]),
            .hit_o   (lane_hit[g]),
            .known_o (lane_known[g])
        );

        cc_flag_cell u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (start_i),
            .load_i  (cmp_valid_i && lane_known[g]),
            .d_i     (lane_hit[g]),
            .q_o     (flag_q[g])
        );
    end

    cc_branch_eval u_branch (
        .flags_i   (flag_q),
        .ref_i     ({ref_y_i, ref_x_i}),
        .combine_i (combine_i),
        .taken_o   (branch_taken_o)
    );

    // Present the stored flags
    always_comb begin
        flags_o = flag_q;
    end

endmodule

// File: rtl/cond_code_unit_chk.sv
// Assertion checker for cond_code_unit, attached by bind.
// Observes ports only.
module cond_code_unit_chk #(
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              cmp_valid_i,
    input logic [DATA_W-1:0] x_a_i,
    input logic [DATA_W-1:0] x_b_i,
    input logic [2:0]        x_mode_i,
    input logic              ref_x_i,
    input logic              ref_y_i,
    input logic [1:0]        combine_i,
    input logic [1:0]        flags_o,
    input logic              branch_taken_o
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (flags_o == 2'b00));

    assert_start_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (flags_o == 2'b00));

    assert_eq_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid_i && !start_i && x_mode_i == 3'd0)
        |=> (flags_o[0] == $past(x_a_i == x_b_i)));

    assert_bad_mode_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid_i && !start_i && x_mode_i > 3'd5)
        |=> (flags_o[0] == $past(flags_o[0])));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_valid_i && !start_i) |=> $stable(flags_o));

    assert_and_combine_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (combine_i == 2'd1 && branch_taken_o)
        |-> (flags_o[0] == ref_x_i && flags_o[1] == ref_y_i));

    assert_or_combine_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (combine_i == 2'd0 && !branch_taken_o)
        |-> (flags_o[0] != ref_x_i && flags_o[1] != ref_y_i));

    assert_signed_lt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid_i && !start_i && x_mode_i == 3'd2
         && x_a_i[DATA_W-1] && !x_b_i[DATA_W-1]) |=> flags_o[0]);

endmodule

bind cond_code_unit cond_code_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .cmp_valid_i    (cmp_valid_i),
    .x_a_i          (x_a_i),
    .x_b_i          (x_b_i),
    .x_mode_i       (x_mode_i),
    .ref_x_i        (ref_x_i),
    .ref_y_i        (ref_y_i),
    .combine_i      (combine_i),
    .flags_o        (flags_o),
    .branch_taken_o (branch_taken_o)
);

// File: tb/test_cond_code_unit.sv
`timescale 1ns/1ps
module test_cond_code_unit;

    localparam int DATA_W = 24;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start_i, cmp_valid_i;
    logic [DATA_W-1:0] x_a_i, x_b_i, y_a_i, y_b_i;
    logic [2:0]        x_mode_i, y_mode_i;
    logic              ref_x_i, ref_y_i;
    logic [1:0]        combine_i;
    logic [1:0]        flags_o;
    logic              branch_taken_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;
    bit  mfx = 1'b0, mfy = 1'b0;

    always #2 clk = ~clk;

    cond_code_unit #(.DATA_W(DATA_W)) i_cond_code_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_valid_i(cmp_valid_i),
        .x_a_i(x_a_i), .x_b_i(x_b_i), .y_a_i(y_a_i), .y_b_i(y_b_i),
        .x_mode_i(x_mode_i), .y_mode_i(y_mode_i),
        .ref_x_i(ref_x_i), .ref_y_i(ref_y_i), .combine_i(combine_i),
        .flags_o(flags_o), .branch_taken_o(branch_taken_o)
    );

    function automatic bit exp_cmp(input logic [2:0] m, input logic [DATA_W-1:0] a,
                                   input logic [DATA_W-1:0] b, input bit old);
        logic signed [DATA_W-1:0] sa, sb;
        sa = a; sb = b;
        case (m)
            3'd0: return sa == sb;
            3'd1: return sa != sb;
            3'd2: return sa < sb;
            3'd3: return sa <= sb;
            3'd4: return sa > sb;
            3'd5: return sa >= sb;
            default: return old;
        endcase
    endfunction

    function automatic bit exp_branch(input bit fx, input bit fy, input bit rx,
                                      input bit ry, input logic [1:0] cb);
        bit cx, cy;
        cx = (fx == rx);
        cy = (fy == ry);
        case (cb)
            2'd0: return cx || cy;
            2'd1: return cx && cy;
            2'd2: return cx;
            default: return cy;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] rnd_val();
        int v;
        if ($urandom_range(0, 7) == 0) return DATA_W'($urandom());
        v = int'($urandom_range(0, 8)) - 4;
        return v[DATA_W-1:0];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, check branch, then check flags after the edge
    task automatic step(input bit st, input bit cv,
                        input logic [DATA_W-1:0] xa, input logic [DATA_W-1:0] xb,
                        input logic [DATA_W-1:0] ya, input logic [DATA_W-1:0] yb,
                        input logic [2:0] mx, input logic [2:0] my,
                        input bit rx, input bit ry, input logic [1:0] cb,
                        input string ftag, input string btag);
        bit nfx, nfy;
        @(negedge clk);
        start_i = st; cmp_valid_i = cv;
        x_a_i = xa; x_b_i = xb; y_a_i = ya; y_b_i = yb;
        x_mode_i = mx; y_mode_i = my;
        ref_x_i = rx; ref_y_i = ry; combine_i = cb;
        #0.5;
        check(btag, {31'd0, branch_taken_o}, {31'd0, exp_branch(mfx, mfy, rx, ry, cb)});
        if (st) begin
            nfx = 1'b0; nfy = 1'b0;
        end else if (cv) begin
            nfx = exp_cmp(mx, xa, xb, mfx);
            nfy = exp_cmp(my, ya, yb, mfy);
        end else begin
            nfx = mfx; nfy = mfy;
        end
        @(posedge clk);
        #1;
        mfx = nfx; mfy = nfy;
        check(ftag, {30'd0, flags_o}, {30'd0, mfy, mfx});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; start_i = 1'b0; cmp_valid_i = 1'b1;
        x_a_i = '0; x_b_i = '0; y_a_i = '0; y_b_i = '0;
        x_mode_i = 3'd0; y_mode_i = 3'd0;
        ref_x_i = 1'b1; ref_y_i = 1'b1; combine_i = 2'd0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset flags", {30'd0, flags_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1; cmp_valid_i = 1'b0;

        // R7: flags are 0, refs 0 -> both checks true
        step(0, 0, 0, 0, 0, 0, 0, 0, 1'b0, 1'b0, 2'd1, "R6 hold", "R7 ref match");
        // R9: -1 < 1 signed; y 5 > 3
        step(0, 1, DATA_W'(-1), DATA_W'(1), DATA_W'(5), DATA_W'(3), 3'd2, 3'd4,
             1'b1, 1'b1, 2'd0, "R9 signed compare", "R7 ref mismatch");
        // R5: x mode 6 holds, y EQ updates
        step(0, 1, DATA_W'(7), DATA_W'(7), DATA_W'(2), DATA_W'(3), 3'd6, 3'd0,
             1'b1, 1'b1, 2'd1, "R5 undefined mode", "R8 and");
        step(0, 1, DATA_W'(2), DATA_W'(2), DATA_W'(2), DATA_W'(3), 3'd0, 3'd7,
             1'b1, 1'b0, 2'd3, "R5 undefined mode y", "R8 y only");
        // R6: data changes without a compare
        step(0, 0, DATA_W'(9), DATA_W'(1), DATA_W'(1), DATA_W'(9), 3'd1, 3'd1,
             1'b0, 1'b0, 2'd2, "R6 hold", "R8 x only");
        // R2: start wins over a compare that would set both
        step(1, 1, DATA_W'(4), DATA_W'(4), DATA_W'(4), DATA_W'(4), 3'd0, 3'd0,
             1'b1, 1'b0, 2'd0, "R2 start clear", "R8 or");
        // R4: independent modes on equal operands
        step(0, 1, DATA_W'(3), DATA_W'(3), DATA_W'(3), DATA_W'(3), 3'd0, 3'd1,
             1'b0, 1'b0, 2'd1, "R4 independent modes", "R8 and");
        step(0, 1, DATA_W'(3), DATA_W'(3), DATA_W'(3), DATA_W'(3), 3'd3, 3'd5,
             1'b1, 1'b1, 2'd0, "R4 le/ge", "R8 or");
        // R3: the flags from a compare are visible to the next branch
        for (int cb = 0; cb < 4; cb++) begin
            for (int r = 0; r < 4; r++) begin
                step(0, 0, 0, 0, 0, 0, 0, 0, r[0], r[1], cb[1:0],
                     "R6 hold", "R8 combine sweep");
            end
        end
        for (int i = 0; i < 600; i++) begin
            step($urandom_range(0, 19) == 0, $urandom_range(0, 3) != 0,
                 rnd_val(), rnd_val(), rnd_val(), rnd_val(),
                 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
                 1'($urandom()), 1'($urandom()), 2'($urandom()),
                 "R3 random compare", "R8 random branch");
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule